// File: doc/BRIEF.md
# Vectored Interrupt Aggregator

This block collects a set of interrupt lines (32 by default) into a single request toward a processor. The kind of each line is fixed when the block is elaborated: a parameter bit of 1 makes that line edge sensitive, and a 0 makes it level sensitive. Software reaches the block through a small bank of 32-bit word registers on a simple select/write bus with no wait states. Through that bank it sees a latched status word, an enable mask, the pending word they produce together, and a vector that names the lowest-numbered pending line.

A two-bit master control register governs the block. Its low bit lets pending interrupts reach the request output. Its high bit hands the capture of status from software to the hardware lines. While the high bit is clear, software may write the status word directly, which allows interrupt handling to be tested without driving the lines. Acknowledging, setting enables and clearing enables each have a write-only location that acts on the bits written as 1.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset, status, enable and master control are all 0, the request output is low, and the vector location reads 0xFFFFFFFF.
- R2: The eight word locations are status 0x00, pending 0x04, enable 0x08, acknowledge 0x0C, set-enable 0x10, clear-enable 0x14, vector 0x18 and master 0x1C. Address bits [1:0] are ignored. The acknowledge, set-enable and clear-enable locations read 0. An address of 0x20 or higher reads 0, and a write to it changes nothing.
- R3: The master register keeps data bits [1:0] only and reads back with bits [31:2] at 0. Bit 0 is the request enable and bit 1 is hardware capture.
- R4: Every line passes through two sampling flops. With hardware capture on, a level line that is high sets its status bit on every cycle. A line raised just after clock edge k shows up in status after edge k+3.
- R5: An edge line sets its status bit once, on a 0-to-1 change of its sampled value. While the line stays high, the bit does not set again after an acknowledge. An edge or a high level that occurs while hardware capture is off is never recorded.
- R6: A write to status replaces its contents only while master bit 1 is 0. While master bit 1 is 1, such a write is ignored.
- R7: A write to acknowledge clears each status bit whose data bit is 1. If a line sets the same bit in that same cycle, the bit stays 1.
- R8: A write to enable replaces the mask. A write to set-enable ORs the data into the mask. A write to clear-enable clears the mask bits where the data is 1.
- R9: The pending location always reads status AND enable.
- R10: The vector location reads the index of the lowest-numbered pending bit. It reads 0xFFFFFFFF when no bit is pending.
- R11: The request output is high exactly when master bit 0 is 1 and pending is nonzero.
- R12: Bit i of parameter EDGE_MASK selects edge (1) or level (0) handling for line i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Bus access strobe, one cycle per access |
| busWrite | input | 1 | 1 for a write, 0 for a read |
| busAddr | input | ADDR_W | Byte address of the word |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data, valid in the cycle of the access |
| irqLines | input | LINES | Interrupt lines |
| irqReq | output | 1 | Request to the processor |

## Verification
The hardest case to produce from the ports is an edge on a line that is already set, arriving in the very cycle that software acknowledges that line. The bench first captures an edge and lowers the line, which leaves the bit set. It then raises the line again and times an acknowledge write so that it commits on the third clock edge after the rise, the edge on which the sampled 0-to-1 change is detected. The bit must survive that acknowledge and clear on a later one. All vector and pending checks are sweeps over every bit position, with each expected value computed by a bench loop.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

  localparam int WORD_IDX_W = 3;
  localparam int IDX_LSB    = 2;

  typedef enum logic [WORD_IDX_W-1:0] {
    W_STATUS  = 3'd0,
    W_PENDING = 3'd1,
    W_ENABLE  = 3'd2,
    W_ACK     = 3'd3,
    W_SETEN   = 3'd4,
    W_CLREN   = 3'd5,
    W_VECTOR  = 3'd6,
    W_MASTER  = 3'd7
  } wordIdx_e;

  typedef enum logic [2:0] {
    RD_ZERO,
    RD_STATUS,
    RD_PENDING,
    RD_ENABLE,
    RD_VECTOR,
    RD_MASTER
  } rdSel_e;

  typedef struct packed {
    logic   wrStatus;
    logic   wrEnable;
    logic   wrAck;
    logic   wrSetEn;
    logic   wrClrEn;
    logic   wrMaster;
    rdSel_e rdSel;
  } strobe_t;

endpackage

// File: rtl/irqv_lowest.sv
module irqv_lowest #(
  parameter int WIDTH = 32,
  parameter int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic [WIDTH-1:0] bits,
  output logic             found,
  output logic [IDX_W-1:0] index
);
  // Scanned from the top down, so the last hit (the lowest index) wins.
  always_comb begin
    found = |bits;
    index = '0;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (bits[i]) index = IDX_W'(i);
    end
  end
endmodule

// File: rtl/irqv_ctrl.sv
module irqv_ctrl
  import irqv_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           strb
);
  localparam int IDX_MSB = IDX_LSB + WORD_IDX_W - 1;

  logic     inMap;
  wordIdx_e idx;

  assign inMap = (busAddr[ADDR_W-1:IDX_MSB+1] == '0);
  assign idx   = wordIdx_e'(busAddr[IDX_MSB:IDX_LSB]);

  always_comb begin
    strb       = '0;
    strb.rdSel = RD_ZERO;
    if (busSel && inMap) begin
      if (busWrite) begin
        case (idx)
          W_STATUS: strb.wrStatus = 1'b1;
          W_ENABLE: strb.wrEnable = 1'b1;
          W_ACK:    strb.wrAck    = 1'b1;
          W_SETEN:  strb.wrSetEn  = 1'b1;
          W_CLREN:  strb.wrClrEn  = 1'b1;
          W_MASTER: strb.wrMaster = 1'b1;
          default:  ;
        endcase
      end else begin
        case (idx)
          W_STATUS:  strb.rdSel = RD_STATUS;
          W_PENDING: strb.rdSel = RD_PENDING;
          W_ENABLE:  strb.rdSel = RD_ENABLE;
          W_VECTOR:  strb.rdSel = RD_VECTOR;
          W_MASTER:  strb.rdSel = RD_MASTER;
          default:   strb.rdSel = RD_ZERO;
        endcase
      end
    end
  end

  // R2: at most one register acted on per access
  p_single_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrStatus, strb.wrEnable, strb.wrAck,
              strb.wrSetEn, strb.wrClrEn, strb.wrMaster}));

  // R2: no write strobe without a mapped write access
  p_write_needs_access_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrStatus || strb.wrEnable || strb.wrAck || strb.wrSetEn ||
     strb.wrClrEn || strb.wrMaster) |-> (busSel && busWrite && inMap));
endmodule

// File: rtl/irqv_datapath.sv
module irqv_datapath
  import irqv_pkg::*;
#(
  parameter int               LINES     = 32,
  parameter int               DATA_W    = 32,
  parameter logic [LINES-1:0] EDGE_MASK = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [LINES-1:0]  lineIn,
  output logic [DATA_W-1:0] rdData,
  output logic              irqReq
);
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1;

  logic [LINES-1:0] syncA, syncB, prevB;
  logic [LINES-1:0] status, nextStatus, enable, pending, hwSet;
  logic [1:0]       master;
  logic             hwEn, masterEn;
  logic             found;
  logic [IDX_W-1:0] lowIdx;
  logic [DATA_W-1:0] vector;
  logic [LINES-1:0] wrLines;

  assign hwEn     = master[1];
  assign masterEn = master[0];
  assign wrLines  = wrData[LINES-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
      prevB <= '0;
    end else begin
      syncA <= lineIn;
      syncB <= syncA;
      prevB <= syncB;
    end
  end

  for (genvar g = 0; g < LINES; g++) begin : g_kind
    if (EDGE_MASK[g]) begin : g_edge
      assign hwSet[g] = hwEn & syncB[g] & ~prevB[g];
    end else begin : g_level
      assign hwSet[g] = hwEn & syncB[g];
    end
  end

  // Set from the lines is applied last so it wins over an acknowledge.
  always_comb begin
    nextStatus = status;
    if (strb.wrStatus && !hwEn) nextStatus = wrLines;
    if (strb.wrAck) nextStatus = nextStatus & ~wrLines;
    nextStatus = nextStatus | hwSet;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      status <= '0;
      enable <= '0;
      master <= '0;
    end else begin
      status <= nextStatus;
      if (strb.wrEnable)      enable <= wrLines;
      else if (strb.wrSetEn)  enable <= enable | wrLines;
      else if (strb.wrClrEn)  enable <= enable & ~wrLines;
      if (strb.wrMaster) master <= wrData[1:0];
    end
  end

  assign pending = status & enable;

  irqv_lowest #(.WIDTH(LINES), .IDX_W(IDX_W)) lowest_i (
    .bits  (pending),
    .found (found),
    .index (lowIdx)
  );

  assign vector = found ? DATA_W'(lowIdx) : '1;
  assign irqReq = masterEn & (|pending);

  always_comb begin
    case (strb.rdSel)
      RD_STATUS:  rdData = DATA_W'(status);
      RD_PENDING: rdData = DATA_W'(pending);
      RD_ENABLE:  rdData = DATA_W'(enable);
      RD_VECTOR:  rdData = vector;
      RD_MASTER:  rdData = DATA_W'(master);
      default:    rdData = '0;
    endcase
  end

  // R6: with capture on, a status write leaves only the line-set bits added
  p_status_locked_r6: assert property (@(posedge clk) disable iff (!rstN)
    (hwEn && strb.wrStatus) |=> (status == ($past(status) | $past(hwSet))));

  // R7: acknowledged bits are clear unless a line set them in that cycle
  p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrAck |=> ((status & $past(wrLines) & ~$past(hwSet)) == '0));

  // R4: a bit set by a line is always recorded
  p_set_recorded_r4: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((status & $past(hwSet)) == $past(hwSet)));

  // R5: nothing is captured from the lines with capture off
  p_no_capture_off_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!hwEn && !strb.wrStatus) |=> ((status & ~$past(status)) == '0));

  // R10: vector points at a pending bit with none below it, or is all ones
  p_vector_low_r10: assert property (@(posedge clk) disable iff (!rstN)
    (pending != '0) |-> (pending[lowIdx] &&
      ((pending & ((LINES'(1) << lowIdx) - LINES'(1))) == '0)));

  p_vector_none_r10: assert property (@(posedge clk) disable iff (!rstN)
    (pending == '0) |-> (vector == '1));

  // R11: request only with master enable and something pending
  p_request_r11: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (master[0] && (status & enable) != '0));
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irqv_pkg::*;
#(
  parameter int               LINES     = 32,
  parameter int               DATA_W    = 32,
  parameter int               ADDR_W    = 8,
  parameter logic [LINES-1:0] EDGE_MASK = 32'hFFFF_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [LINES-1:0]  irqLines,
  output logic              irqReq
);
  strobe_t strb;

  irqv_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .strb     (strb)
  );

  irqv_datapath #(.LINES(LINES), .DATA_W(DATA_W), .EDGE_MASK(EDGE_MASK)) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wrData (busWdata),
    .lineIn (irqLines),
    .rdData (busRdata),
    .irqReq (irqReq)
  );
endmodule

// File: tb/irq_vec_ctrl_tb_top.sv
module irq_vec_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] EDGES = 32'hFFFF_0000;

  localparam logic [7:0] A_STATUS = 8'h00, A_PEND = 8'h04, A_EN = 8'h08,
                         A_ACK = 8'h0C, A_SETEN = 8'h10, A_CLREN = 8'h14,
                         A_VEC = 8'h18, A_MASTER = 8'h1C;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWrite = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0, busRdata;
  logic [31:0] irqLines = '0;
  logic        irqReq;
  int nChecks = 0, nFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_vec_ctrl #(.LINES(32), .DATA_W(32), .ADDR_W(8), .EDGE_MASK(EDGES)) dut_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .irqLines(irqLines), .irqReq(irqReq)
  );

  function automatic logic [31:0] lowestOf(input logic [31:0] v);
    for (int i = 0; i < 32; i++) if (v[i]) return 32'(i);
    return 32'hFFFF_FFFF;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic busWr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic busRd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    #1 d = busRdata;
    busSel = 1'b0;
  endtask

  task automatic expectReg(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    busRd(a, v);
    check(tag, v, exp);
  endtask

  task automatic waitNeg(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [31:0] st, en;
    waitNeg(3);
    rstN = 1'b1;

    // R1: reset values
    expectReg("R1 status", A_STATUS, 32'h0);
    expectReg("R1 pending", A_PEND, 32'h0);
    expectReg("R1 enable", A_EN, 32'h0);
    expectReg("R1 vector", A_VEC, 32'hFFFF_FFFF);
    expectReg("R1 master", A_MASTER, 32'h0);
    check("R1 request", 32'(irqReq), 32'h0);

    // R2: out-of-map writes change nothing, read zero
    busWr(8'h20, 32'hFFFF_FFFF);
    busWr(8'h48, 32'hFFFF_FFFF);
    busWr(8'hFC, 32'hFFFF_FFFF);
    expectReg("R2 oob status", A_STATUS, 32'h0);
    expectReg("R2 oob enable", A_EN, 32'h0);
    expectReg("R2 oob master", A_MASTER, 32'h0);
    expectReg("R2 oob read", 8'h20, 32'h0);
    expectReg("R2 low addr bits ignored", 8'h1B, 32'hFFFF_FFFF);

    // R6 R9 R10: test-mode status writes, vector sweep
    busWr(A_EN, 32'hFFFF_FFFF);
    for (int i = 0; i < 32; i++) begin
      st = 32'hFFFF_FFFF << i;
      busWr(A_STATUS, st);
      expectReg("R10 vector sweep", A_VEC, 32'(i));
      expectReg("R9 pending sweep", A_PEND, st);
    end
    for (int i = 0; i < 32; i++) begin
      st = 32'hA5C3_5A3C ^ (32'h1 << i);
      en = ~(32'h1 << i) & 32'hF0F0_FF0F;
      busWr(A_STATUS, st);
      busWr(A_EN, en);
      expectReg("R6 status readback", A_STATUS, st);
      expectReg("R9 pending mixed", A_PEND, st & en);
      expectReg("R10 vector mixed", A_VEC, lowestOf(st & en));
    end
    busWr(A_STATUS, 32'h0);
    expectReg("R10 vector none", A_VEC, 32'hFFFF_FFFF);

    // R8: enable operations
    busWr(A_EN, 32'h1234_0000);
    busWr(A_SETEN, 32'h0000_00FF);
    expectReg("R8 set-enable", A_EN, 32'h1234_00FF);
    busWr(A_CLREN, 32'h1200_000F);
    expectReg("R8 clear-enable", A_EN, 32'h0034_00F0);
    expectReg("R2 set-enable reads zero", A_SETEN, 32'h0);
    expectReg("R2 clear-enable reads zero", A_CLREN, 32'h0);

    // R7: acknowledge
    busWr(A_STATUS, 32'hFFFF_FFFF);
    busWr(A_ACK, 32'h0F0F_0F0F);
    expectReg("R7 ack clears", A_STATUS, 32'hF0F0_F0F0);
    expectReg("R2 ack reads zero", A_ACK, 32'h0);

    // R3 R11: master control and request
    busWr(A_STATUS, 32'h0000_0001);
    busWr(A_EN, 32'h0000_0001);
    check("R11 no master enable", 32'(irqReq), 32'h0);
    busWr(A_MASTER, 32'hFFFF_FFFD);
    expectReg("R3 master bits", A_MASTER, 32'h1);
    check("R11 request high", 32'(irqReq), 32'h1);
    busWr(A_EN, 32'h0000_0002);
    check("R11 nothing pending", 32'(irqReq), 32'h0);
    busWr(A_EN, 32'h0000_0001);
    check("R11 request again", 32'(irqReq), 32'h1);
    busWr(A_MASTER, 32'h0);
    check("R11 master off", 32'(irqReq), 32'h0);

    // R6: status write ignored with capture on
    busWr(A_MASTER, 32'h3);
    expectReg("R3 master both", A_MASTER, 32'h3);
    busWr(A_STATUS, 32'h0000_FF00);
    expectReg("R6 locked status", A_STATUS, 32'h1);
    busWr(A_ACK, 32'hFFFF_FFFF);
    expectReg("R7 ack with capture on", A_STATUS, 32'h0);

    // R4 R12: level line 3 timing and re-set
    busWr(A_EN, 32'hFFFF_FFFF);
    @(negedge clk); irqLines[3] = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R4 not yet after two edges", 32'(irqReq), 32'h0);
    @(negedge clk);
    check("R4 request after third edge", 32'(irqReq), 32'h1);
    expectReg("R4 level set", A_STATUS, 32'h8);
    busWr(A_ACK, 32'h8);
    expectReg("R4 level re-sets while high", A_STATUS, 32'h8);
    irqLines[3] = 1'b0;
    waitNeg(4);
    busWr(A_ACK, 32'h8);
    expectReg("R4 level cleared after drop", A_STATUS, 32'h0);

    // R5 R12: edge line 20
    @(negedge clk); irqLines[20] = 1'b1;
    waitNeg(4);
    expectReg("R5 edge captured", A_STATUS, 32'h0010_0000);
    expectReg("R10 vector edge", A_VEC, 32'd20);
    busWr(A_ACK, 32'h0010_0000);
    waitNeg(4);
    expectReg("R5 no re-set while held", A_STATUS, 32'h0);
    irqLines[20] = 1'b0;
    waitNeg(4);

    // R5: capture off loses edges and levels
    busWr(A_MASTER, 32'h1);
    irqLines[21] = 1'b1;
    irqLines[5]  = 1'b1;
    waitNeg(4);
    expectReg("R5 nothing captured off", A_STATUS, 32'h0);
    irqLines[5] = 1'b0;
    waitNeg(4);
    busWr(A_MASTER, 32'h3);
    waitNeg(4);
    expectReg("R5 edge lost while off", A_STATUS, 32'h0);
    irqLines[21] = 1'b0;

    // R7 R12: edge on line 22 coincides with acknowledge
    @(negedge clk); irqLines[22] = 1'b1;
    waitNeg(4);
    irqLines[22] = 1'b0;
    waitNeg(4);
    expectReg("R12 edge bit held after drop", A_STATUS, 32'h0040_0000);
    @(negedge clk); irqLines[22] = 1'b1;
    @(negedge clk);
    busWr(A_ACK, 32'h0040_0000);
    expectReg("R7 set wins over ack", A_STATUS, 32'h0040_0000);
    busWr(A_ACK, 32'h0040_0000);
    expectReg("R7 later ack clears", A_STATUS, 32'h0);
    irqLines[22] = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule